// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous, pipelined burst SRAM. The bus needs no idle cycle when it turns from read to write or back. Every enabled rising edge may start a read, a write or a deselect. Read data leaves an output register one edge after the address was taken. Write data is sampled from the data bus one edge after its address was taken.

Accepted write data waits in a one-entry buffer and is committed to the array on the next enabled edge. A read of the same word issued in the cycle right after the write gets the new bytes forwarded from that buffer. A load/advance strobe lets one address drive a short wrapping burst, and a parameter picks a linear or an interleaved beat order. An asynchronous output enable and a sleep input control the bus drivers. The bidirectional data bus is split into `dq_in`, `dq_out` and a drive enable `dq_oe`.

Top module: `sram_nt_core`

## Requirements
- R1: While reset is active, and after it is released until the first read has finished its pipeline, `dq_oe` is low.
- R2: A read is issued at an enabled edge when `load_n`=0, `sel0_n`=0, `sel1`=1, `sel2_n`=0 and `wr_n`=1. After the next enabled edge, `dq_out` holds the addressed word, and `dq_oe` is high while `drv_en_n`=0 and `doze`=0.
- R3: A write is issued like a read but with `wr_n`=0. The data is sampled from `dq_in` at the next enabled edge. Lane i is bits [9i+8:9i], and only lanes whose `lane_wr_n[i]` was 0 when the address was issued are updated. With all bits of `lane_wr_n` high, the word is left unchanged.
- R4: After the edge that samples write data, `dq_oe` is low, whatever the value of `drv_en_n`.
- R5: With `load_n`=0, any inactive chip enable (`sel0_n`=1, `sel1`=0 or `sel2_n`=1) is a deselect, whatever `wr_n` is. Data from an earlier read stays driven through the edge that takes the deselect. `dq_oe` goes low after the following edge, and the array is not changed.
- R6: `drv_en_n`=1 turns `dq_oe` off at once, without waiting for a clock edge, and setting it back to 0 restores the pending read data.
- R7: An edge with `clk_en_n`=1 is ignored. The pipeline, the outputs and the array keep their values, and the command present at that edge is never executed.
- R8: With `load_n`=1, an enabled edge issues the operation of the last load again at the next burst address. The low log2(BURST) address bits step and wrap around, and the upper bits are kept. The chip enables and `wr_n` are ignored at that edge.
- R9: With INTERLEAVE=0, beat k uses low bits (start + k) mod 4. With INTERLEAVE=1, beat k uses start XOR k. For start 1, this gives 1,2,3,0,1 in the linear order and 1,0,3,2,1 in the interleaved order.
- R10: A read of the word written by the immediately preceding command returns the newly written lanes merged with the old contents of the unwritten lanes.
- R11: While `doze`=1, `dq_oe` is low. An edge with `doze`=1 starts no access and drops any read or write whose data has not yet been taken. The array contents are kept.
- R12: Reads and writes can alternate on consecutive edges with no idle cycle, and every access completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en_n | input | 1 | Active-low clock qualifier; high freezes the block |
| sel0_n | input | 1 | Chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| sel2_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | Low loads a new command; high advances the burst |
| wr_n | input | 1 | Low selects a write, high a read, on a load |
| lane_wr_n | input | 4 | Active-low per-lane write strobes |
| addr | input | 6 | Word address |
| drv_en_n | input | 1 | Asynchronous active-low output drive enable |
| doze | input | 1 | Active-high sleep |
| dq_in | input | 36 | Write data from the bus |
| dq_out | output | 36 | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
A read taken at edge k is checked in the low clock phase after edge k+1. The sample points are counted one edge at a time, so both early and late data are caught. Write data is driven in the cycle after its address and checked later by readback. A forwarded read is checked one cycle after the write's data cycle. The bus release after a write or a deselect is sampled exactly two edges after the command was issued, and the data that is still driven one edge earlier is checked as well. The output-enable and sleep gating are checked a short time after the input changes, within one clock phase. A second instance built with the interleaved order runs beside the first and is checked against its own reference memory.

// File: rtl/sram_nt_pkg.sv
package sram_nt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/sram_nt_ctrl.sv
// Command decode, burst sequencing and the address/control stage.
module sram_nt_ctrl
  import sram_nt_pkg::*;
#(
  parameter int AW         = 6,
  parameter int LANES      = 4,
  parameter int CW         = 2,
  parameter bit INTERLEAVE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             doze,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             load_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    addr,
  output op_e              s1_op,
  output logic [AW-1:0]    s1_addr,
  output logic [LANES-1:0] s1_be
);

  op_e              op_q, op_d, bop_q, bop_d, new_op;
  logic [AW-1:0]    addr_q, addr_d, base_q, base_d, step_addr;
  logic [LANES-1:0] be_q, be_d;
  logic [CW-1:0]    cnt_q, cnt_d, cnt_inc;
  logic             chip_on;

  assign cnt_inc = cnt_q + CW'(1);

  generate
    if (INTERLEAVE) begin : g_ilv
      assign step_addr = {base_q[AW-1:CW], base_q[CW-1:0] ^ cnt_inc};
    end else begin : g_lin
      assign step_addr = {base_q[AW-1:CW], base_q[CW-1:0] + cnt_inc};
    end
  endgenerate

  always_comb begin
    chip_on = !sel0_n && sel1 && !sel2_n;
    new_op  = chip_on ? (wr_n ? OP_READ : OP_WRITE) : OP_IDLE;
  end

  always_comb begin
    op_d   = op_q;
    bop_d  = bop_q;
    addr_d = addr_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    be_d   = be_q;
    if (doze) begin
      op_d  = OP_IDLE;
      bop_d = OP_IDLE;
    end else if (!clk_en_n) begin
      be_d = ~lane_wr_n;
      if (!load_n) begin
        op_d   = new_op;
        bop_d  = new_op;
        addr_d = addr;
        base_d = addr;
        cnt_d  = '0;
      end else begin
        op_d   = bop_q;
        addr_d = step_addr;
        cnt_d  = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      bop_q  <= OP_IDLE;
      addr_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      be_q   <= '0;
    end else begin
      op_q   <= op_d;
      bop_q  <= bop_d;
      addr_q <= addr_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      be_q   <= be_d;
    end
  end

  assign s1_op   = op_q;
  assign s1_addr = addr_q;
  assign s1_be   = be_q;

endmodule

// File: rtl/sram_nt_array.sv
// Storage: one bank per byte lane, synchronous masked write, combinational read.
module sram_nt_array #(
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES-1:0]        wbe,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
        if (we && wbe[g]) begin
          bank[waddr] <= wdata[g*LANE_W +: LANE_W];
        end
      end

      assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
    end
  endgenerate

endmodule

// File: rtl/sram_nt_datapath.sv
// Late-write buffer, read forwarding, output register and drive gating.
module sram_nt_datapath
  import sram_nt_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    doze,
  input  logic                    drv_en_n,
  input  op_e                     s1_op,
  input  logic [AW-1:0]           s1_addr,
  input  logic [LANES-1:0]        s1_be,
  input  logic [LANES*LANE_W-1:0] dq_in,
  input  logic [LANES*LANE_W-1:0] mem_rdata,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_waddr,
  output logic [LANES-1:0]        mem_wbe,
  output logic [LANES*LANE_W-1:0] mem_wdata,
  output logic [AW-1:0]           mem_raddr,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe,
  output logic                    out_vld
);

  localparam int DW = LANES * LANE_W;

  logic             wb_vld_q, wb_vld_d;
  logic [AW-1:0]    wb_addr_q, wb_addr_d;
  logic [LANES-1:0] wb_be_q, wb_be_d;
  logic [DW-1:0]    wb_data_q, wb_data_d;
  logic             out_vld_q, out_vld_d;
  logic [DW-1:0]    out_data_q, out_data_d;
  logic [DW-1:0]    fwd_word;
  logic             addr_hit;

  assign addr_hit = wb_vld_q && (wb_addr_q == s1_addr);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_fwd
      assign fwd_word[g*LANE_W +: LANE_W] = (addr_hit && wb_be_q[g])
                                            ? wb_data_q[g*LANE_W +: LANE_W]
                                            : mem_rdata[g*LANE_W +: LANE_W];
    end
  endgenerate

  always_comb begin
    wb_vld_d   = wb_vld_q;
    wb_addr_d  = wb_addr_q;
    wb_be_d    = wb_be_q;
    wb_data_d  = wb_data_q;
    out_vld_d  = out_vld_q;
    out_data_d = out_data_q;
    if (adv) begin
      if (doze) begin
        wb_vld_d  = 1'b0;
        out_vld_d = 1'b0;
      end else begin
        wb_vld_d  = (s1_op == OP_WRITE);
        wb_addr_d = s1_addr;
        wb_be_d   = s1_be;
        wb_data_d = dq_in;
        out_vld_d = (s1_op == OP_READ);
        if (s1_op == OP_READ) begin
          out_data_d = fwd_word;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_vld_q   <= 1'b0;
      wb_addr_q  <= '0;
      wb_be_q    <= '0;
      wb_data_q  <= '0;
      out_vld_q  <= 1'b0;
      out_data_q <= '0;
    end else begin
      wb_vld_q   <= wb_vld_d;
      wb_addr_q  <= wb_addr_d;
      wb_be_q    <= wb_be_d;
      wb_data_q  <= wb_data_d;
      out_vld_q  <= out_vld_d;
      out_data_q <= out_data_d;
    end
  end

  assign mem_we    = adv && wb_vld_q;
  assign mem_waddr = wb_addr_q;
  assign mem_wbe   = wb_be_q;
  assign mem_wdata = wb_data_q;
  assign mem_raddr = s1_addr;
  assign dq_out    = out_data_q;
  assign dq_oe     = out_vld_q && !drv_en_n && !doze;
  assign out_vld   = out_vld_q;

endmodule

// File: rtl/sram_nt_core.sv
module sram_nt_core
  import sram_nt_pkg::*;
#(
  parameter int  DEPTH      = 64,
  parameter int  LANES      = 4,
  parameter int  LANE_W     = 9,
  parameter int  BURST      = 4,
  parameter bit  INTERLEAVE = 1'b0,
  localparam int AW         = $clog2(DEPTH),
  localparam int DW         = LANES * LANE_W,
  localparam int CW         = $clog2(BURST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             load_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    addr,
  input  logic             drv_en_n,
  input  logic             doze,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);

  logic [1:0]       rst_pipe;
  logic             rst_q_n;
  logic             adv;
  op_e              s1_op;
  logic [AW-1:0]    s1_addr;
  logic [LANES-1:0] s1_be;
  logic             mem_we;
  logic [AW-1:0]    mem_waddr, mem_raddr;
  logic [LANES-1:0] mem_wbe;
  logic [DW-1:0]    mem_wdata, mem_rdata;
  logic             out_vld;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe[1];

  // pipeline moves on enabled edges; sleep flushes it on any edge
  assign adv = !clk_en_n || doze;

  sram_nt_ctrl #(
    .AW(AW), .LANES(LANES), .CW(CW), .INTERLEAVE(INTERLEAVE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .clk_en_n(clk_en_n), .doze(doze),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .load_n(load_n),
    .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
  );

  sram_nt_array #(
    .DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)
  ) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wbe(mem_wbe),
    .wdata(mem_wdata), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  sram_nt_datapath #(
    .AW(AW), .LANES(LANES), .LANE_W(LANE_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_q_n), .adv(adv), .doze(doze), .drv_en_n(drv_en_n),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be), .dq_in(dq_in),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wbe(mem_wbe), .mem_wdata(mem_wdata), .mem_raddr(mem_raddr),
    .dq_out(dq_out), .dq_oe(dq_oe), .out_vld(out_vld)
  );

endmodule

// File: rtl/sram_nt_chk.sv
module sram_nt_chk
  import sram_nt_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 36,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          doze,
  input logic          load_n,
  input op_e           s1_op,
  input logic [AW-1:0] s1_addr,
  input logic          out_vld,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe
);

  a_r2_read_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !doze && s1_op == OP_READ) |=> out_vld);

  a_r4_write_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !doze && s1_op == OP_WRITE) |=> !dq_oe);

  a_r5_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !doze && s1_op == OP_IDLE) |=> !dq_oe);

  a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !doze) |=> ($stable(dq_out) && $stable(s1_op) && $stable(s1_addr)));

  a_r8_burst_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !doze && load_n) |=>
      (s1_op == $past(s1_op) && s1_addr[AW-1:CW] == $past(s1_addr[AW-1:CW])));

  a_r11_sleep_flush: assert property (@(posedge clk) disable iff (!rst_n)
    doze |=> (s1_op == OP_IDLE && !out_vld));

endmodule

bind sram_nt_core sram_nt_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .clk_en_n(clk_en_n), .doze(doze),
  .load_n(load_n), .s1_op(s1_op), .s1_addr(s1_addr), .out_vld(out_vld),
  .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/tb_sram_nt_core.sv
`timescale 1ns/1ps
module tb_sram_nt_core;

  localparam logic [2:0]  CE_ON = 3'b010;
  localparam logic [2:0]  CE_DS = 3'b110;
  localparam logic [35:0] GARB  = 36'hA_5A5A_5A5A;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_en_n, sel0_n, sel1, sel2_n, load_n, wr_n, drv_en_n, doze;
  logic [3:0]  lane_wr_n;
  logic [5:0]  addr;
  logic [35:0] dq_in, dq_out, dq_out_i;
  logic        dq_oe, dq_oe_i;

  logic [35:0] ref_l [64];
  logic [35:0] ref_i [64];
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sram_nt_core #(.INTERLEAVE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .load_n(load_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .drv_en_n(drv_en_n), .doze(doze), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  sram_nt_core #(.INTERLEAVE(1'b1)) dut_ilv (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .load_n(load_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .drv_en_n(drv_en_n), .doze(doze), .dq_in(dq_in),
    .dq_out(dq_out_i), .dq_oe(dq_oe_i)
  );

  function automatic logic [35:0] pat(input int i);
    logic [35:0] r;
    for (int g = 0; g < 4; g++) r[g*9 +: 9] = 9'((i * 37 + g * 101 + 11) & 511);
    return r;
  endfunction

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                        input logic [3:0] bw);
    logic [35:0] r;
    r = old;
    for (int g = 0; g < 4; g++) if (!bw[g]) r[g*9 +: 9] = nw[g*9 +: 9];
    return r;
  endfunction

  task automatic chk_w(input string rq, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic chk_b(input string rq, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put(input logic ld, input logic [2:0] ce, input logic we,
                     input logic [3:0] bw, input logic [5:0] a, input logic [35:0] d);
    load_n = ld;
    {sel0_n, sel1, sel2_n} = ce;
    wr_n = we;
    lane_wr_n = bw;
    addr = a;
    dq_in = d;
  endtask

  task automatic put_ds(input logic [35:0] d);
    put(1'b0, CE_DS, 1'b1, 4'hF, 6'd0, d);
  endtask

  // read one word and check both instances; ends with the data on the bus
  task automatic rd_chk(input logic [5:0] a, input string rq);
    tick(); put(1'b0, CE_ON, 1'b1, 4'hF, a, GARB);
    tick(); put_ds(GARB);
    tick();
    chk_b(rq, dq_oe, 1'b1);
    chk_w(rq, dq_out, ref_l[a]);
    chk_w(rq, dq_out_i, ref_i[a]);
  endtask

  task automatic t_reset();
    chk_b("R1 idle after reset", dq_oe, 1'b0);
    chk_b("R1 idle after reset ilv", dq_oe_i, 1'b0);
  endtask

  // back-to-back writes, data one cycle behind its address (R12, R3)
  task automatic t_fill();
    for (int i = 0; i < 64; i++) begin
      tick(); put(1'b0, CE_ON, 1'b0, 4'h0, 6'(i), (i > 0) ? pat(i - 1) : GARB);
      ref_l[i] = pat(i);
      ref_i[i] = pat(i);
    end
    tick(); put_ds(pat(63));
    tick(); tick();
    rd_chk(6'd0, "R3 fill word 0");
    rd_chk(6'd17, "R2 read word 17");
    rd_chk(6'd63, "R12 last streamed word");
    tick();
    chk_b("R5 off after deselect", dq_oe, 1'b0);
  endtask

  task automatic t_alternate();
    logic [35:0] d1, d2;
    d1 = pat(100);
    d2 = pat(200);
    tick(); put(1'b0, CE_ON, 1'b0, 4'h0, 6'd3, GARB);
    tick(); put(1'b0, CE_ON, 1'b1, 4'hF, 6'd40, d1);
    tick(); put(1'b0, CE_ON, 1'b0, 4'h0, 6'd41, GARB);
    tick();
    chk_b("R12 read between writes oe", dq_oe, 1'b1);
    chk_w("R12 read between writes", dq_out, ref_l[40]);
    put(1'b0, CE_ON, 1'b1, 4'hF, 6'd3, d2);
    ref_l[3] = d1; ref_i[3] = d1;
    ref_l[41] = d2; ref_i[41] = d2;
    tick();
    chk_b("R4 bus released after write data", dq_oe, 1'b0);
    put_ds(GARB);
    tick();
    chk_w("R12 read after write", dq_out, d1);
    chk_b("R12 read after write oe", dq_oe, 1'b1);
    tick();
    chk_b("R5 off after deselect", dq_oe, 1'b0);
    rd_chk(6'd41, "R12 second write");
  endtask

  task automatic t_forward();
    logic [35:0] nd;
    nd = pat(333);
    tick(); put(1'b0, CE_ON, 1'b0, 4'b1010, 6'd20, GARB);
    tick(); put(1'b0, CE_ON, 1'b1, 4'hF, 6'd20, nd);
    tick(); put_ds(GARB);
    ref_l[20] = merge(ref_l[20], nd, 4'b1010);
    ref_i[20] = ref_l[20];
    tick();
    chk_w("R10 forwarded partial write", dq_out, ref_l[20]);
    chk_w("R10 forwarded partial write ilv", dq_out_i, ref_i[20]);
    rd_chk(6'd20, "R3 lane mask after commit");
    tick(); put(1'b0, CE_ON, 1'b0, 4'hF, 6'd21, GARB);
    tick(); put_ds(nd);
    tick();
    rd_chk(6'd21, "R3 all strobes high leaves word");
  endtask

  task automatic t_deselect();
    logic [2:0] codes [3];
    codes[0] = 3'b110; codes[1] = 3'b000; codes[2] = 3'b011;
    for (int k = 0; k < 3; k++) begin
      tick(); put(1'b0, CE_ON, 1'b1, 4'hF, 6'd30, GARB);
      tick(); put(1'b0, codes[k], 1'b0, 4'h0, 6'd30, GARB);
      tick();
      chk_b("R5 data held through deselect edge", dq_oe, 1'b1);
      chk_w("R5 data held through deselect edge", dq_out, ref_l[30]);
      put_ds(GARB);
      tick();
      chk_b("R5 deselect tri-states", dq_oe, 1'b0);
    end
    rd_chk(6'd30, "R5 deselect leaves array");
  endtask

  task automatic t_oe();
    rd_chk(6'd17, "R2 read for output enable");
    drv_en_n = 1'b1;
    #1;
    chk_b("R6 async disable", dq_oe, 1'b0);
    drv_en_n = 1'b0;
    #1;
    chk_b("R6 async enable", dq_oe, 1'b1);
    chk_w("R6 data kept", dq_out, ref_l[17]);
  endtask

  task automatic t_hold();
    tick(); put_ds(GARB);
    tick(); tick();
    put(1'b0, CE_ON, 1'b1, 4'hF, 6'd33, GARB);
    tick(); clk_en_n = 1'b1; put(1'b0, CE_ON, 1'b0, 4'h0, 6'd31, GARB);
    tick();
    chk_b("R7 held edge loads nothing", dq_oe, 1'b0);
    clk_en_n = 1'b0; put_ds(GARB);
    tick();
    chk_b("R7 read resumes", dq_oe, 1'b1);
    chk_w("R7 read resumes", dq_out, ref_l[33]);
    rd_chk(6'd31, "R7 held write not done");
  endtask

  task automatic t_burst();
    int lin_rd [5];
    int ilv_rd [5];
    logic [35:0] bd [4];
    lin_rd = '{5, 6, 7, 4, 5};
    ilv_rd = '{5, 4, 7, 6, 5};
    tick(); put(1'b0, CE_ON, 1'b1, 4'hF, 6'd5, GARB);
    tick(); put(1'b1, 3'b110, 1'b0, 4'h0, 6'd0, GARB);
    for (int k = 0; k < 5; k++) begin
      tick();
      chk_b("R8 burst beat oe", dq_oe, 1'b1);
      chk_w("R8 linear burst beat", dq_out, ref_l[lin_rd[k]]);
      chk_w("R9 interleaved burst beat", dq_out_i, ref_i[ilv_rd[k]]);
      if (k < 3) put(1'b1, 3'b000, 1'b0, 4'h0, 6'd0, GARB);
      else put_ds(GARB);
    end
    tick();
    chk_b("R8 burst ends on deselect", dq_oe, 1'b0);
    for (int k = 0; k < 4; k++) bd[k] = pat(500 + k);
    tick(); put(1'b0, CE_ON, 1'b0, 4'h0, 6'd9, GARB);
    tick(); put(1'b1, CE_DS, 1'b1, 4'h0, 6'd0, bd[0]);
    tick(); put(1'b1, CE_DS, 1'b1, 4'h0, 6'd0, bd[1]);
    tick(); put(1'b1, CE_DS, 1'b1, 4'h0, 6'd0, bd[2]);
    tick(); put_ds(bd[3]);
    ref_l[9] = bd[0]; ref_l[10] = bd[1]; ref_l[11] = bd[2]; ref_l[8] = bd[3];
    ref_i[9] = bd[0]; ref_i[8] = bd[1]; ref_i[11] = bd[2]; ref_i[10] = bd[3];
    tick();
    for (int a = 8; a < 12; a++) rd_chk(6'(a), "R9 burst write order");
  endtask

  task automatic t_sleep();
    rd_chk(6'd17, "R11 read before sleep");
    doze = 1'b1;
    #1;
    chk_b("R11 sleep gates drivers", dq_oe, 1'b0);
    put(1'b0, CE_ON, 1'b1, 4'hF, 6'd40, GARB);
    tick(); doze = 1'b0;
    chk_b("R11 no access during sleep", dq_oe, 1'b0);
    put_ds(GARB);
    tick();
    chk_b("R11 read at sleep edge ignored", dq_oe, 1'b0);
    put(1'b0, CE_ON, 1'b1, 4'hF, 6'd17, GARB);
    tick(); doze = 1'b1; put_ds(GARB);
    tick(); doze = 1'b0;
    chk_b("R11 in-flight read dropped", dq_oe, 1'b0);
    put(1'b0, CE_ON, 1'b0, 4'h0, 6'd50, GARB);
    tick(); doze = 1'b1; put_ds(pat(777));
    tick(); doze = 1'b0;
    rd_chk(6'd50, "R11 write without data dropped");
    rd_chk(6'd3, "R11 array kept");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clk_en_n = 1'b0;
    drv_en_n = 1'b0;
    doze = 1'b0;
    put_ds(GARB);
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_fill();
    t_alternate();
    t_forward();
    t_deselect();
    t_oe();
    t_hold();
    t_burst();
    t_sleep();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule